// File: doc/BRIEF.md
# Low-Transition Test Pattern Generator

This block produces stimulus vectors for a built-in self-test run. A 36-bit maximal-length shift register with XOR feedback supplies the true pseudo-random states. The block does not jump straight from one state to the next. It walks between them through three blended vectors. The bit positions are split into four groups by index modulo 4. Each blended vector copies one more group from the next state. As a result, a bit of the pattern toggles at most once between two true states, and the switching seen by the circuit under test over a step is no more than the Hamming distance of the two states.

Each register step takes five enabled clocks, which the block calls phases 0 to 4. Phase 0 presents the current state T1 and raises the true-state flag. Phases 1 to 3 present the blended vectors. Phase 4 presents the successor T2. On the next enabled edge the register advances, so T2 becomes the new phase-0 vector. A seed strobe restarts the sequence from any non-zero value. The enable pauses the sequence, and a valid strobe trails the enable by one clock.

Top module: `ltg_lowtrans_tpg`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block resets. After that edge `pattern` = 36'h4A5AD296B, `true_state` = 1 and `pattern_valid` = 0.
- R2: The successor of state S is {S[34:0], S[35] ^ S[24]}, which is the polynomial x^36 + x^25 + 1. The register state is never all-zero.
- R3: With T1 as the current state and T2 as its successor, the output at phase k (k = 0..4) takes bit i from T2 when (i mod 4) < k, and from T1 otherwise. Each enabled edge adds one to the phase. The edge that leaves phase 4 loads T2 into the register and returns the phase to 0.
- R4: Within one step (T1 through the five vectors to T2), no bit changes twice. The sum of the Hamming distances between consecutive outputs equals the Hamming distance from T1 to T2.
- R5: `true_state` is 1 exactly when the phase is 0, and 0 during phases 1 to 4.
- R6: An edge with `enable` = 0 and `seed_load` = 0 leaves both `pattern` and the phase unchanged.
- R7: After each edge, `pattern_valid` equals the value `enable` had at that edge.
- R8: An edge with `seed_load` = 1 loads `seed_value` into the register and sets the phase to 0, whatever `enable` is. `pattern` then equals the seed and `true_state` = 1.
- R9: A seed load with `seed_value` = 0 loads 36'h4A5AD296B instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for all flip-flops |
| rst_n | input | 1 | Synchronous reset, active low |
| enable | input | 1 | Advances the phase on each edge while high |
| seed_load | input | 1 | Loads `seed_value` and restarts at phase 0; overrides `enable` |
| seed_value | input | 36 | Seed for the shift register (zero selects the default) |
| pattern | output | 36 | Vector for the circuit under test |
| pattern_valid | output | 1 | `enable` delayed by one clock |
| true_state | output | 1 | High when `pattern` is a genuine register state (phase 0) |

## Verification
The assertions assume that `rst_n` is held low for at least one clock edge before any check matters, and that the inputs settle before each rising edge. Under those conditions the per-edge change checks are valid from the first edge after reset. The step-transition assertion applies only on edges where `seed_load` is low, because a load may change any number of bits at once. The bench changes inputs only on the falling edge and resets at the start. It issues seed loads deliberately and separately from the runs that measure toggling, and it includes a zero seed and an all-ones seed.

// File: rtl/ltg_pkg.sv
// Shared constants and types for the low-transition pattern generator.
// Assumes a 36-bit register with taps at 36 and 25 and four bit groups.
package ltg_pkg;
    localparam int          LTG_W      = 36;
    localparam int          LTG_TAP_HI = 36;
    localparam int          LTG_TAP_LO = 25;
    localparam int          LTG_GROUPS = 4;
    localparam logic [35:0] LTG_SEED   = 36'h4A5AD296B;
    localparam int          LTG_PW     = $clog2(LTG_GROUPS + 1);
    typedef logic [LTG_PW-1:0] phase_t;
endpackage

// File: rtl/ltg_lfsr_core.sv
// Fibonacci shift register with two XOR taps.
// Outputs the present state and its combinational successor.
// Assumes the tap pair gives a maximal-length sequence, so a non-zero
// state never reaches zero. A zero load value is replaced by SEED.
module ltg_lfsr_core #(
    parameter int          W      = 36,
    parameter int          TAP_HI = 36,
    parameter int          TAP_LO = 25,
    parameter logic [W-1:0] SEED  = 36'h4A5AD296B
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         advance,
    output logic [W-1:0] state,
    output logic [W-1:0] succ
);
    logic feedback;

    // Feedback bit from the two taps.
    always_comb feedback = state[TAP_HI-1] ^ state[TAP_LO-1];

    // Next register value: shift left, feedback enters at bit 0.
    always_comb succ = {state[W-2:0], feedback};

    // State register: reset, seed load, or a one-step advance.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= SEED;
        else if (load)
            state <= (load_val == '0) ? SEED : load_val;
        else if (advance)
            state <= succ;
    end

    // R2
    state_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (state != '0));

    // R9
    zero_seed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && load_val == '0) |=> (state == SEED));
endmodule

// File: rtl/ltg_phase_seq.sv
// Phase counter for one register step: runs 0..GROUPS and wraps to 0.
// Raises wrap on the enabled edge that leaves the last phase.
// Assumes load takes priority over enable.
module ltg_phase_seq #(
    parameter int GROUPS = 4,
    localparam int PW    = $clog2(GROUPS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          load,
    output logic [PW-1:0] phase,
    output logic          wrap
);
    localparam logic [PW-1:0] LAST = PW'(GROUPS);

    // Wrap request on the final phase of an enabled, non-loading edge.
    always_comb wrap = enable && !load && (phase == LAST);

    // Phase register: cleared by reset or load, counted by enable.
    always_ff @(posedge clk) begin
        if (!rst_n || load)
            phase <= '0;
        else if (wrap)
            phase <= '0;
        else if (enable)
            phase <= phase + 1'b1;
    end

    // R3
    phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (phase <= LAST));

    // R6
    phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && !load) |=> $stable(phase));

    // R8
    load_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (phase == '0));
endmodule

// File: rtl/ltg_blend.sv
// Per-bit selector between T1 and T2.
// Bit i takes T2 once the phase exceeds (i mod GROUPS).
// Purely combinational. Assumes phase <= GROUPS.
module ltg_blend #(
    parameter int W      = 36,
    parameter int GROUPS = 4,
    localparam int PW    = $clog2(GROUPS + 1)
) (
    input  logic [W-1:0]  t1,
    input  logic [W-1:0]  t2,
    input  logic [PW-1:0] phase,
    output logic [W-1:0]  mixed
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        localparam logic [PW-1:0] GRP = PW'(i % GROUPS);
        // Select the source of this bit from its group and the phase.
        always_comb mixed[i] = (GRP < phase) ? t2[i] : t1[i];
    end
endmodule

// File: rtl/ltg_lowtrans_tpg.sv
// Top of the low-transition pattern generator.
// Ties together the shift register, the phase sequencer and the blend mux,
// and registers the valid strobe.
// Assumes a synchronous active-low reset and one common clock.
module ltg_lowtrans_tpg #(
    parameter int           W      = ltg_pkg::LTG_W,
    parameter int           TAP_HI = ltg_pkg::LTG_TAP_HI,
    parameter int           TAP_LO = ltg_pkg::LTG_TAP_LO,
    parameter int           GROUPS = ltg_pkg::LTG_GROUPS,
    parameter logic [W-1:0] SEED   = ltg_pkg::LTG_SEED
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         enable,
    input  logic         seed_load,
    input  logic [W-1:0] seed_value,
    output logic [W-1:0] pattern,
    output logic         pattern_valid,
    output logic         true_state
);
    localparam int PW = $clog2(GROUPS + 1);

    logic [W-1:0]  cur_state;
    logic [W-1:0]  nxt_state;
    logic [PW-1:0] phase;
    logic          step_wrap;
    logic [W-1:0]  grp_mask;

    ltg_lfsr_core #(.W(W), .TAP_HI(TAP_HI), .TAP_LO(TAP_LO), .SEED(SEED)) u_core (
        .clk(clk), .rst_n(rst_n), .load(seed_load), .load_val(seed_value),
        .advance(step_wrap), .state(cur_state), .succ(nxt_state)
    );

    ltg_phase_seq #(.GROUPS(GROUPS)) u_seq (
        .clk(clk), .rst_n(rst_n), .enable(enable), .load(seed_load),
        .phase(phase), .wrap(step_wrap)
    );

    ltg_blend #(.W(W), .GROUPS(GROUPS)) u_blend (
        .t1(cur_state), .t2(nxt_state), .phase(phase), .mixed(pattern)
    );

    // Flag the vectors that are genuine register states.
    always_comb true_state = (phase == '0);

    // Valid strobe trails the enable by one clock.
    always_ff @(posedge clk) begin
        if (!rst_n) pattern_valid <= 1'b0;
        else        pattern_valid <= enable;
    end

    // Bits allowed to change on the edge leaving the present phase.
    for (genvar i = 0; i < W; i++) begin : g_mask
        localparam logic [PW-1:0] GRP = PW'(i % GROUPS);
        always_comb grp_mask[i] = (GRP == phase);
    end

    // R4
    group_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !seed_load) |=> (((pattern ^ $past(pattern)) & ~$past(grp_mask)) == '0));

    // R6
    pattern_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && !seed_load) |=> $stable(pattern));

    // R7
    valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        enable |=> pattern_valid);

    // R7
    valid_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !pattern_valid);

    // R8
    load_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seed_load && seed_value != '0) |=> (pattern == $past(seed_value) && true_state));
endmodule

// File: tb/ltg_lowtrans_tpg_tb.sv
module ltg_lowtrans_tpg_tb;
    localparam logic [35:0] DEF = 36'h4A5AD296B;
    localparam int NROW = 22;
    // Each entry is {enable, seed_load, seed_value}.
    localparam logic [37:0] STIM [0:NROW-1] = '{
        {2'b10, 36'h0}, {2'b10, 36'h0}, {2'b10, 36'h0}, {2'b10, 36'h0},
        {2'b10, 36'h0}, {2'b00, 36'h0}, {2'b00, 36'h0}, {2'b10, 36'h0},
        {2'b10, 36'h0}, {2'b01, 36'h123456789}, {2'b10, 36'h0}, {2'b10, 36'h0},
        {2'b10, 36'h0}, {2'b10, 36'h0}, {2'b10, 36'h0}, {2'b10, 36'h0},
        {2'b11, 36'h0}, {2'b10, 36'h0}, {2'b11, 36'hFFFFFFFFF}, {2'b10, 36'h0},
        {2'b00, 36'h0}, {2'b10, 36'h0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        seed_load = 1'b0;
    logic [35:0] seed_value = '0;
    logic [35:0] pattern;
    logic        pattern_valid;
    logic        true_state;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [35:0] m_cur;
    int          m_phase;
    logic        m_valid;

    always #10 clk = ~clk;

    ltg_lowtrans_tpg u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .seed_load(seed_load),
        .seed_value(seed_value), .pattern(pattern),
        .pattern_valid(pattern_valid), .true_state(true_state)
    );

    function automatic logic [35:0] succ_of(input logic [35:0] s);
        return {s[34:0], s[35] ^ s[24]};
    endfunction

    function automatic logic [35:0] mix(input logic [35:0] a, input logic [35:0] b, input int ph);
        logic [35:0] r;
        for (int i = 0; i < 36; i++) r[i] = ((i % 4) < ph) ? b[i] : a[i];
        return r;
    endfunction

    task automatic check36(input string tag, input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_step(input logic en, input logic ld, input logic [35:0] sd);
        if (ld) begin
            m_cur = (sd == '0) ? DEF : sd;
            m_phase = 0;
        end else if (en) begin
            if (m_phase == 4) begin
                m_cur = succ_of(m_cur);
                m_phase = 0;
            end else m_phase++;
        end
        m_valid = en;
    endtask

    task automatic cycle(input logic en, input logic ld, input logic [35:0] sd);
        enable = en; seed_load = ld; seed_value = sd;
        @(posedge clk);
        @(negedge clk);
        model_step(en, ld, sd);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; enable = 1'b0; seed_load = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_cur = DEF; m_phase = 0; m_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R1: reset state
        check36("R1 pattern", pattern, DEF);
        check36("R1 true_state", {35'b0, true_state}, 36'd1);
        check36("R1 valid", {35'b0, pattern_valid}, 36'd0);

        // Table walk: R3, R5, R6, R7, R8, R9 against the model
        for (int r = 0; r < NROW; r++) begin
            logic en, ld;
            logic [35:0] sd;
            string tag;
            {en, ld, sd} = STIM[r];
            cycle(en, ld, sd);
            if (ld && sd == '0) tag = "R9";
            else if (ld) tag = "R8";
            else if (!en) tag = "R6";
            else tag = "R3";
            check36($sformatf("%s pattern row %0d", tag, r), pattern,
                    mix(m_cur, succ_of(m_cur), m_phase));
            check36($sformatf("R5 true_state row %0d", r), {35'b0, true_state},
                    {35'b0, m_phase == 0});
            check36($sformatf("R7 valid row %0d", r), {35'b0, pattern_valid},
                    {35'b0, m_valid});
        end

        // R4 and R2: toggle discipline over four full steps from the default seed
        do_reset();
        for (int s = 0; s < 4; s++) begin
            logic [35:0] t1, prev, diff, toggled;
            int sum;
            t1 = pattern; prev = pattern; toggled = '0; sum = 0;
            for (int k = 0; k < 5; k++) begin
                cycle(1'b1, 1'b0, '0);
                diff = pattern ^ prev;
                check36($sformatf("R4 retoggle step %0d vec %0d", s, k), diff & toggled, 36'h0);
                toggled |= diff;
                sum += $countones(diff);
                prev = pattern;
            end
            check36($sformatf("R4 hamming sum step %0d", s), 36'(sum), 36'($countones(t1 ^ pattern)));
            check36($sformatf("R2 successor step %0d", s), pattern, succ_of(t1));
            check36($sformatf("R5 flag at step end %0d", s), {35'b0, true_state}, 36'd1);
        end

        // R9: zero seed while disabled still loads the default
        cycle(1'b0, 1'b1, '0);
        check36("R9 zero seed", pattern, DEF);
        // R6: held pattern while disabled in mid-step
        cycle(1'b1, 1'b0, '0);
        cycle(1'b1, 1'b0, '0);
        begin
            logic [35:0] held;
            held = pattern;
            cycle(1'b0, 1'b0, '0);
            cycle(1'b0, 1'b0, '0);
            check36("R6 hold mid-step", pattern, held);
            check36("R5 low mid-step", {35'b0, true_state}, 36'd0);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule